// File: doc/BRIEF.md
# Overlay Mesh Routing Switch

This block is one routing node of a mesh of coarse-grained compute tiles. Five sources feed it: the switches to the north, east, south and west, and the compute unit that sits to its north-west. It drives eight destinations, one toward each compass direction. Each destination has its own selector, which picks one of the five sources, and its own flow-control engine. A word moves to a destination only when that receiver has buffer room.

Routes are set by writing one destination slot at a time through a parallel configuration port. They are held fixed while a kernel runs. An upstream sender presents a word with `in_valid` and holds it there. The switch acknowledges the word with a one-cycle `in_credit` pulse once every active destination that selects that source has taken the word. Each destination pushes a word downstream as a one-cycle `out_valid` pulse and spends one credit for it. The receiver gives the credit back with a one-cycle `cr_ret` pulse.

Top module: `ovl_route_switch`

## Requirements
- R1: After reset every destination is disabled, `out_valid` and `in_credit` are all low, and every credit counter holds CREDIT_DEPTH.
- R2: Source codes are 0 north, 1 east, 2 south, 3 west and 4 north-west compute unit. Word k of `in_data` sits at bits [16k+15:16k], and destination d uses bits [16d+15:16d] of `out_data`. A forwarded word reaches the selected destination with all 16 bits unchanged.
- R3: A destination sends only while its credit count is nonzero, and that count never exceeds CREDIT_DEPTH. With no credits returned, exactly CREDIT_DEPTH words pass and the next word stalls.
- R4: Each word sent lowers the destination's credit count by one. Each `cr_ret` pulse raises it by one, so a stalled word moves on after a credit comes back.
- R5: `in_credit[k]` pulses high for the cycle before the clock edge at which the word is accepted. In the cycle after that edge, the word's `out_valid` is high for exactly one cycle.
- R6: When several active destinations select the same source, that source is acknowledged only after all of them have taken the word. Each of them receives the word exactly once, even when one of them is held back by credits.
- R7: A destination whose enable bit is clear never raises `out_valid`.
- R8: A select code of 5, 6 or 7 makes a destination inactive. It never raises `out_valid`.
- R9: A source that no active destination selects is never acknowledged. Its word stays pending.
- R10: A write with `cfg_wr` high loads `cfg_sel` and `cfg_en` into the slot named by `cfg_port`, and the new route applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_port | input | 3 | Destination slot to write |
| cfg_sel | input | 3 | Source select code |
| cfg_en | input | 1 | Destination enable |
| in_data | input | 80 | Five packed 16-bit source words |
| in_valid | input | 5 | Source word present, held until acknowledged |
| in_credit | output | 5 | Per-source acknowledge (credit back upstream) |
| out_data | output | 128 | Eight packed 16-bit destination words |
| out_valid | output | 8 | One-cycle push per word to each destination |
| cr_ret | input | 8 | Credit-return pulses from downstream receivers |

## Verification
The bench builds the switch with its defaults: 16-bit words, five sources, eight destinations and a credit depth of two. With a depth of two, credit exhaustion and a stalled third word can be reached after only a couple of transfers, including inside a fan-out where one branch is starved while the other has already taken the word. A 3-bit select field over five sources leaves codes 5 to 7 free, which lets the bench exercise invalid selects next to disabled slots and unrouted sources.

// File: rtl/sw_route_pkg.sv
package sw_route_pkg;
   typedef enum logic [1:0] {
      OS_OFF  = 2'd0,
      OS_WAIT = 2'd1,
      OS_HELD = 2'd2
   } out_state_e;
endpackage

// File: rtl/sw_cfg_bank.sv
module sw_cfg_bank #(
   parameter int N_IN  = 5,
   parameter int N_OUT = 8,
   parameter int SEL_W = 3,
   parameter int IDX_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [IDX_W-1:0]       port,
   input  logic [SEL_W-1:0]       sel_in,
   input  logic                   en_in,
   output logic [N_OUT*SEL_W-1:0] sel_q,
   output logic [N_OUT-1:0]       act_q
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_slot
      logic [SEL_W-1:0] sel_r;
      logic             en_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sel_r <= '0;
            en_r  <= 1'b0;
         end else if (wr && port == IDX_W'(o)) begin
            sel_r <= sel_in;
            en_r  <= en_in;
         end
      end
      assign sel_q[o*SEL_W +: SEL_W] = sel_r;
      assign act_q[o] = en_r && ({1'b0, sel_r} < (SEL_W+1)'(N_IN));
   end
endmodule

// File: rtl/sw_in_release.sv
module sw_in_release #(
   parameter int N_IN  = 5,
   parameter int N_OUT = 8,
   parameter int SEL_W = 3
) (
   input  logic [N_IN-1:0]        in_valid,
   input  logic [N_OUT-1:0]       act,
   input  logic [N_OUT*SEL_W-1:0] sel,
   input  logic [N_OUT-1:0]       done,
   output logic [N_IN-1:0]        consume
);
   for (genvar i = 0; i < N_IN; i++) begin : g_src
      logic [N_OUT-1:0] users;
      always_comb begin
         for (int o = 0; o < N_OUT; o++)
            users[o] = act[o] && (sel[o*SEL_W +: SEL_W] == SEL_W'(i));
         consume[i] = in_valid[i] && (|users) && (&(~users | done));
      end
   end
endmodule

// File: rtl/sw_out_port.sv
module sw_out_port
   import sw_route_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int N_IN         = 5,
   parameter int SEL_W        = 3,
   parameter int CREDIT_DEPTH = 2,
   parameter int CNT_W        = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN*DATA_W-1:0] in_data,
   input  logic [N_IN-1:0]        in_valid,
   input  logic [N_IN-1:0]        consume,
   input  logic                   active,
   input  logic [SEL_W-1:0]       sel,
   input  logic                   cr_ret,
   output logic [DATA_W-1:0]      out_data,
   output logic                   out_valid,
   output logic                   fire,
   output logic                   held,
   output logic [CNT_W-1:0]       credit
);
   out_state_e       st_q, st_d;
   logic [DATA_W-1:0] pick_data;
   logic              pick_vld;
   logic              rel;
   logic [CNT_W-1:0]  cr_q, cr_d;

   always_comb begin
      pick_data = '0;
      pick_vld  = 1'b0;
      rel       = 1'b0;
      for (int k = 0; k < N_IN; k++) begin
         if (sel == SEL_W'(k)) begin
            pick_data = in_data[k*DATA_W +: DATA_W];
            pick_vld  = in_valid[k];
            rel       = consume[k];
         end
      end
   end

   assign fire = active && (st_q != OS_HELD) && pick_vld && (cr_q != '0);
   assign held = (st_q == OS_HELD);

   always_comb begin
      st_d = st_q;
      if (!active)
         st_d = OS_OFF;
      else if (st_q == OS_HELD)
         st_d = rel ? OS_WAIT : OS_HELD;
      else
         st_d = (fire && !rel) ? OS_HELD : OS_WAIT;
   end

   always_comb begin
      cr_d = cr_q;
      if (fire && !cr_ret)
         cr_d = cr_q - CNT_W'(1);
      else if (!fire && cr_ret)
         cr_d = cr_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= OS_OFF;
         cr_q      <= CNT_W'(CREDIT_DEPTH);
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         st_q      <= st_d;
         cr_q      <= cr_d;
         out_valid <= fire;
         if (fire) out_data <= pick_data;
      end
   end

   assign credit = cr_q;
endmodule

// File: rtl/ovl_route_switch.sv
module ovl_route_switch #(
   parameter int DATA_W       = 16,
   parameter int N_IN         = 5,
   parameter int N_OUT        = 8,
   parameter int CREDIT_DEPTH = 2,
   localparam int SEL_W = (N_IN  > 1) ? $clog2(N_IN)  : 1,
   localparam int IDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
   localparam int CNT_W = $clog2(CREDIT_DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr,
   input  logic [IDX_W-1:0]        cfg_port,
   input  logic [SEL_W-1:0]        cfg_sel,
   input  logic                    cfg_en,
   input  logic [N_IN*DATA_W-1:0]  in_data,
   input  logic [N_IN-1:0]         in_valid,
   output logic [N_IN-1:0]         in_credit,
   output logic [N_OUT*DATA_W-1:0] out_data,
   output logic [N_OUT-1:0]        out_valid,
   input  logic [N_OUT-1:0]        cr_ret
);
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end
   if (N_IN < 2 || N_OUT < 1) begin : g_bad_ports
      $error("need at least two sources and one destination");
   end
   if (CREDIT_DEPTH < 1) begin : g_bad_depth
      $error("CREDIT_DEPTH must be at least one");
   end

   logic [N_OUT*SEL_W-1:0] sel_q;
   logic [N_OUT-1:0]       act_q;
   logic [N_OUT-1:0]       fire;
   logic [N_OUT-1:0]       held;
   logic [N_IN-1:0]        consume;
   logic [N_OUT*CNT_W-1:0] credit_flat;

   sw_cfg_bank #(
      .N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .IDX_W(IDX_W)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .port(cfg_port),
      .sel_in(cfg_sel), .en_in(cfg_en), .sel_q(sel_q), .act_q(act_q)
   );

   sw_in_release #(
      .N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)
   ) i_rel (
      .in_valid(in_valid), .act(act_q), .sel(sel_q),
      .done(held | fire), .consume(consume)
   );

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      sw_out_port #(
         .DATA_W(DATA_W), .N_IN(N_IN), .SEL_W(SEL_W),
         .CREDIT_DEPTH(CREDIT_DEPTH), .CNT_W(CNT_W)
      ) i_port (
         .clk(clk), .rst_n(rst_n),
         .in_data(in_data), .in_valid(in_valid), .consume(consume),
         .active(act_q[o]), .sel(sel_q[o*SEL_W +: SEL_W]),
         .cr_ret(cr_ret[o]),
         .out_data(out_data[o*DATA_W +: DATA_W]),
         .out_valid(out_valid[o]),
         .fire(fire[o]), .held(held[o]),
         .credit(credit_flat[o*CNT_W +: CNT_W])
      );
   end

   assign in_credit = consume;
endmodule

// File: rtl/sw_route_checker.sv
module sw_route_checker #(
   parameter int N_IN         = 5,
   parameter int N_OUT        = 8,
   parameter int CREDIT_DEPTH = 2,
   parameter int CNT_W        = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [N_IN-1:0]        in_valid,
   input logic [N_IN-1:0]        in_credit,
   input logic [N_OUT-1:0]       out_valid,
   input logic [N_OUT-1:0]       cr_ret,
   input logic [N_OUT-1:0]       act_q,
   input logic [N_OUT*CNT_W-1:0] credit_flat
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_o
      p_credit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
         credit_flat[o*CNT_W +: CNT_W] <= CNT_W'(CREDIT_DEPTH));
      p_send_needs_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[o] |-> $past(credit_flat[o*CNT_W +: CNT_W]) != '0);
      p_credit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[o] && !$past(cr_ret[o])) |->
            (credit_flat[o*CNT_W +: CNT_W] == $past(credit_flat[o*CNT_W +: CNT_W]) - CNT_W'(1)));
      p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(act_q[o]) |-> !out_valid[o]);
   end
   for (genvar i = 0; i < N_IN; i++) begin : g_i
      p_ack_needs_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
         in_credit[i] |-> in_valid[i]);
   end
endmodule

bind ovl_route_switch sw_route_checker #(
   .N_IN(N_IN), .N_OUT(N_OUT), .CREDIT_DEPTH(CREDIT_DEPTH), .CNT_W(CNT_W)
) i_route_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_credit(in_credit),
   .out_valid(out_valid), .cr_ret(cr_ret), .act_q(act_q),
   .credit_flat(credit_flat)
);

// File: tb/test_ovl_route_switch.sv
module test_ovl_route_switch;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int NI = 5;
   localparam int NO = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_wr = 1'b0;
   logic [2:0]     cfg_port = '0;
   logic [2:0]     cfg_sel = '0;
   logic           cfg_en = 1'b0;
   logic [NI*DW-1:0] in_data = '0;
   logic [NI-1:0]  in_valid = '0;
   logic [NI-1:0]  in_credit;
   logic [NO*DW-1:0] out_data;
   logic [NO-1:0]  out_valid;
   logic [NO-1:0]  cr_ret = '0;

   int errors = 0;
   int checks = 0;
   logic [DW-1:0] exp_q [NO][$];
   int rx_cnt [NO];
   int owed [NO];
   bit hold_ret [NO];

   always #(CLK_PERIOD/2) clk = ~clk;

   ovl_route_switch i_ovl_route_switch (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_port(cfg_port),
      .cfg_sel(cfg_sel), .cfg_en(cfg_en), .in_data(in_data),
      .in_valid(in_valid), .in_credit(in_credit), .out_data(out_data),
      .out_valid(out_valid), .cr_ret(cr_ret)
   );

   task automatic fail(input string req, input string what, input int act, input int exp);
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) fail(req, what, act, exp);
   endtask

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // scoreboard monitor and downstream credit model
   initial begin
      for (int o = 0; o < NO; o++) begin
         rx_cnt[o] = 0; owed[o] = 0; hold_ret[o] = 1'b0;
      end
      forever begin
         @(negedge clk);
         cr_ret = '0;
         if (rst_n) begin
            for (int o = 0; o < NO; o++) begin
               if (out_valid[o]) begin
                  checks++;
                  rx_cnt[o]++;
                  owed[o]++;
                  if (exp_q[o].size() == 0) begin
                     fail("R6/R7", $sformatf("unexpected word on out%0d", o),
                          int'(out_data[o*DW +: DW]), 0);
                  end else begin
                     logic [DW-1:0] e;
                     e = exp_q[o].pop_front();
                     if (out_data[o*DW +: DW] != e)
                        fail("R2", $sformatf("data on out%0d", o),
                             int'(out_data[o*DW +: DW]), int'(e));
                  end
               end
               if (!hold_ret[o] && owed[o] > 0) begin
                  cr_ret[o] = 1'b1;
                  owed[o]--;
               end
            end
         end
      end
   end

   task automatic cfg(input int o, input int s, input bit en);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_port = 3'(o); cfg_sel = 3'(s); cfg_en = en;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic send(input int i, input logic [DW-1:0] d, input logic [NO-1:0] mask, input bit lat);
      for (int o = 0; o < NO; o++) if (mask[o]) exp_q[o].push_back(d);
      @(negedge clk);
      in_data[i*DW +: DW] = d;
      in_valid[i] = 1'b1;
      #1;
      while (!in_credit[i]) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      in_valid[i] = 1'b0;
      if (lat) begin
         for (int o = 0; o < NO; o++) begin
            if (mask[o]) begin
               check("R5", $sformatf("valid one cycle after ack, out%0d", o), int'(out_valid[o]), 1);
               check("R5", $sformatf("data after ack, out%0d", o),
                     int'(out_data[o*DW +: DW]), int'(d));
            end
         end
         @(negedge clk);
         for (int o = 0; o < NO; o++)
            if (mask[o]) check("R5", $sformatf("single-cycle valid, out%0d", o), int'(out_valid[o]), 0);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (CLK_PERIOD * 2000) @(posedge clk);
      fail("WDOG", "watchdog expired", 1, 0);
      report();
   end

   initial begin
      int b1, b5, b2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "out_valid after reset", int'(out_valid), 0);
      check("R1", "in_credit after reset", int'(in_credit), 0);

      // R2 R10: single routes; north -> east, compute unit -> north-west
      cfg(2, 0, 1'b1);
      send(0, 16'hA5A5, 8'b0000_0100, 1'b1);
      cfg(7, 4, 1'b1);
      send(4, 16'h1234, 8'b1000_0000, 1'b1);
      cfg(3, 1, 1'b1);
      cfg(0, 2, 1'b1);
      fork
         send(1, 16'hBEEF, 8'b0000_1000, 1'b1);
         send(2, 16'h0F0F, 8'b0000_0001, 1'b1);
      join

      // R6: fan-out of west to outputs 1 and 5
      cfg(1, 3, 1'b1);
      cfg(5, 3, 1'b1);
      send(3, 16'hC001, 8'b0010_0010, 1'b1);
      idle(3);

      // R3 R4: credit exhaustion on output 2
      b2 = rx_cnt[2];
      hold_ret[2] = 1'b1;
      send(0, 16'h1111, 8'b0000_0100, 1'b1);
      send(0, 16'h2222, 8'b0000_0100, 1'b1);
      fork
         send(0, 16'h3333, 8'b0000_0100, 1'b0);
         begin
            idle(6);
            check("R3", "words passed with no credit back", rx_cnt[2] - b2, 2);
            check("R3", "stalled source not acknowledged", int'(in_credit[0]), 0);
            hold_ret[2] = 1'b0;
         end
      join
      idle(2);
      check("R4", "stalled word released by credit return", rx_cnt[2] - b2, 3);

      // R6: fan-out with one branch starved
      b1 = rx_cnt[1];
      b5 = rx_cnt[5];
      hold_ret[5] = 1'b1;
      send(3, 16'h4444, 8'b0010_0010, 1'b1);
      send(3, 16'h5555, 8'b0010_0010, 1'b1);
      fork
         send(3, 16'h6666, 8'b0010_0010, 1'b0);
         begin
            idle(6);
            check("R6", "free branch took word once", rx_cnt[1] - b1, 3);
            check("R6", "starved branch waits", rx_cnt[5] - b5, 2);
            check("R6", "source held while a branch waits", int'(in_credit[3]), 0);
            hold_ret[5] = 1'b0;
         end
      join
      idle(3);
      check("R6", "no duplicate on free branch", rx_cnt[1] - b1, 3);
      check("R6", "starved branch finally served", rx_cnt[5] - b5, 3);

      // R7: disabled slot selecting an active source
      cfg(6, 0, 1'b0);
      send(0, 16'h7777, 8'b0000_0100, 1'b1);
      check("R7", "disabled output silent", rx_cnt[6], 0);

      // R8: invalid select code
      cfg(6, 6, 1'b1);
      send(0, 16'h8888, 8'b0000_0100, 1'b1);
      check("R8", "select code 6 silent", rx_cnt[6], 0);
      cfg(6, 7, 1'b1);
      send(0, 16'h9999, 8'b0000_0100, 1'b1);
      check("R8", "select code 7 silent", rx_cnt[6], 0);

      // R9: south source with no user
      cfg(0, 2, 1'b0);
      begin
         int seen;
         seen = 0;
         @(negedge clk);
         in_data[2*DW +: DW] = 16'hDEAD;
         in_valid[2] = 1'b1;
         for (int c = 0; c < 6; c++) begin
            #1;
            if (in_credit[2]) seen++;
            @(negedge clk);
         end
         in_valid[2] = 1'b0;
         check("R9", "unrouted source never acknowledged", seen, 0);
         check("R9", "no output for unrouted source", rx_cnt[0], 1);
      end

      // R10: reroute output 0 to the compute unit
      cfg(0, 4, 1'b1);
      send(4, 16'hABCD, 8'b1000_0001, 1'b1);
      idle(4);
      begin
         int left;
         left = 0;
         for (int o = 0; o < NO; o++) left += exp_q[o].size();
         check("R2", "all expected words delivered", left, 0);
      end
      report();
   end
endmodule